// File: doc/BRIEF.md
# Audio Codec Controller Register Front End

This block is the memory-mapped register front end of an AC97-style audio controller. It holds two sample queues of 16-bit entries. The host fills one queue with samples for playback, and the audio slot logic drains it one sample per strobe. The slot logic fills the other queue with captured samples, and the host drains it by reading a register. A packed status word reports the fill state of both queues, two sticky error flags, the codec-ready input and a completion flag for codec register accesses.

The host reaches codec registers through three registers: an address/command register, a write-data register and a read-data register. For a write, the host first loads the write-data register, then writes the address/command register with the direction bit clear, which launches the access. For a read, it writes the address/command register with the direction bit set and polls the completion flag until the codec data is in the read-data register. Toward the codec link engine the block holds a request with address, direction and data until the engine returns a one-cycle done pulse. The block drives two interrupt lines, one per direction, from the queue fill levels.

Top module: `audio_ctl_regs`

## Requirements
- R1: The register is selected by byte offset (bus_addr[4:2]): 0x00 playback queue, 0x04 record queue, 0x08 status, 0x0C queue flush, 0x10 codec address/command, 0x14 codec read data, 0x18 codec write data. The command and write-data registers read back their stored values, and offsets 0x1C and above read zero.
- R2: A bus write to 0x00 pushes bits 15:0 of the data word into the 32-entry playback queue. A push while the queue is full is dropped. Each play_take strobe removes the oldest entry, and play_sample shows that entry.
- R3: A rec_put strobe pushes rec_sample into the 32-entry record queue, and a put while the queue is full is dropped. A bus read of 0x04 returns the oldest entry in bits 15:0 with the upper bits zero, and removes it.
- R4: Status word layout: bit7 record overrun, bit6 playback underrun, bit5 codec ready, bit4 access finished, bit3 record empty, bit2 record full, bit1 playback at half or below (16 or fewer entries), bit0 playback full. Bits 31:8 read zero.
- R5: Writing 0x0C with bit0 set empties the playback queue, and writing it with bit1 set empties the record queue. Both bits may be set in one write. Each flush also clears the sticky flag of its own direction. The register has no storage and reads zero.
- R6: A write to 0x10 with bit7 clear launches a codec write. cdc_req rises with cdc_rd=0, cdc_addr set to bits 6:0 and cdc_wdata set to the write-data register. All of these hold until cdc_done.
- R7: A write to 0x10 with bit7 set launches a codec read with cdc_rd=1. Any launch clears the access-finished bit. On cdc_done the bit sets and the request drops. For a read, cdc_rdata is also captured into the 0x14 register. A write access leaves that register unchanged.
- R8: A write to 0x10 while a request is outstanding is ignored.
- R9: A play_take on an empty playback queue sets the underrun flag, and a rec_put on a full record queue sets the overrun flag. Both flags stay set until the flush of their own direction.
- R10: play_irq is high while the playback queue holds 16 or fewer entries. rec_irq is high while the record queue holds 16 or more.
- R11: A read of 0x04 with the record queue empty returns zero and leaves the queue empty. play_sample is zero while the playback queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| cdc_ready | input | 1 | Codec ready indication |
| cdc_req | output | 1 | Codec access request, held until done |
| cdc_rd | output | 1 | Request direction, 1 = read |
| cdc_addr | output | 7 | Codec register address |
| cdc_wdata | output | 16 | Codec write data |
| cdc_done | input | 1 | Access complete pulse |
| cdc_rdata | input | 16 | Codec read data, valid with cdc_done |
| play_take | input | 1 | Slot strobe consuming one playback sample |
| play_sample | output | 16 | Oldest playback sample, zero if empty |
| rec_put | input | 1 | Slot strobe delivering one record sample |
| rec_sample | input | 16 | Record sample |
| play_irq | output | 1 | Playback interrupt |
| rec_irq | output | 1 | Record interrupt |

## Verification
The hardest conditions to reach are the ones at the queue edges: the 33rd push, the fill counts of 16 and 17 where the interrupts switch, and the sticky flags, which are set only by a take from an empty queue or a put into a full one. The bench fills each queue past full through the ports and then drains it one entry at a time, checking the interrupt at every level. The overlapping codec launch needs the second write to land while a stub codec still holds its done pulse back, so the stub answers only after three cycles of request.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;
    localparam int SAMPLE_W = 16;
    localparam int DATA_W   = 32;
    localparam int CADDR_W  = 7;

    typedef enum logic [2:0] {
        REG_PLAY   = 3'd0,
        REG_REC    = 3'd1,
        REG_STAT   = 3'd2,
        REG_FLUSH  = 3'd3,
        REG_CADDR  = 3'd4,
        REG_CRDATA = 3'd5,
        REG_CWDATA = 3'd6
    } reg_idx_e;

    typedef struct packed {
        logic rec_ovr;
        logic play_und;
        logic codec_rdy;
        logic acc_done;
        logic rec_empty;
        logic rec_full;
        logic play_half;
        logic play_full;
    } status_t;

    typedef struct packed {
        logic               rd;
        logic [CADDR_W-1:0] addr;
    } caddr_t;

    function automatic logic [DATA_W-1:0] widen(input logic [SAMPLE_W-1:0] s);
        return {{(DATA_W-SAMPLE_W){1'b0}}, s};
    endfunction
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/codec_port.sv
module codec_port
    import audio_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                launch,
    input  caddr_t              cmd,
    input  logic [SAMPLE_W-1:0] wdata_in,
    output logic                cdc_req,
    output caddr_t              cur_cmd,
    output logic [SAMPLE_W-1:0] cdc_wdata,
    input  logic                cdc_done,
    input  logic [SAMPLE_W-1:0] cdc_rdata,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                finished
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cdc_req   <= 1'b0;
            cur_cmd   <= '0;
            cdc_wdata <= '0;
            rd_data   <= '0;
            finished  <= 1'b0;
        end else if (cdc_req) begin
            if (cdc_done) begin
                cdc_req  <= 1'b0;
                finished <= 1'b1;
                if (cur_cmd.rd) rd_data <= cdc_rdata;
            end
        end else if (launch) begin
            cdc_req   <= 1'b1;
            cur_cmd   <= cmd;
            cdc_wdata <= wdata_in;
            finished  <= 1'b0;
        end
    end
endmodule

// File: rtl/audio_ctl_regs.sv
module audio_ctl_regs
    import audio_ctl_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [4:0]          bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                cdc_ready,
    output logic                cdc_req,
    output logic                cdc_rd,
    output logic [CADDR_W-1:0]  cdc_addr,
    output logic [SAMPLE_W-1:0] cdc_wdata,
    input  logic                cdc_done,
    input  logic [SAMPLE_W-1:0] cdc_rdata,
    input  logic                play_take,
    output logic [SAMPLE_W-1:0] play_sample,
    input  logic                rec_put,
    input  logic [SAMPLE_W-1:0] rec_sample,
    output logic                play_irq,
    output logic                rec_irq
);
    localparam int CW   = $clog2(DEPTH+1);
    localparam int HALF = DEPTH / 2;

    reg_idx_e            word;
    logic                wr_en, rd_en;
    logic                play_push, rec_pop, flush_play, flush_rec, launch;
    logic [SAMPLE_W-1:0] play_head, rec_head, cw_q, crd_q;
    logic [CW-1:0]       play_cnt, rec_cnt;
    logic                play_full, play_empty, rec_full, rec_empty;
    logic                und_q, ovr_q, acc_fin;
    caddr_t              cur_cmd;
    status_t             stat_w;

    assign word       = reg_idx_e'(bus_addr[4:2]);
    assign wr_en      = bus_sel && bus_wr;
    assign rd_en      = bus_sel && !bus_wr;
    assign play_push  = wr_en && word == REG_PLAY;
    assign rec_pop    = rd_en && word == REG_REC;
    assign flush_play = wr_en && word == REG_FLUSH && bus_wdata[0];
    assign flush_rec  = wr_en && word == REG_FLUSH && bus_wdata[1];
    assign launch     = wr_en && word == REG_CADDR;

    sample_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_play (
        .clk(clk), .rst(rst), .flush(flush_play),
        .push(play_push), .din(bus_wdata[SAMPLE_W-1:0]),
        .pop(play_take), .dout(play_head), .count(play_cnt),
        .full(play_full), .empty(play_empty)
    );

    sample_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_rec (
        .clk(clk), .rst(rst), .flush(flush_rec),
        .push(rec_put), .din(rec_sample),
        .pop(rec_pop), .dout(rec_head), .count(rec_cnt),
        .full(rec_full), .empty(rec_empty)
    );

    codec_port u_codec (
        .clk(clk), .rst(rst), .launch(launch),
        .cmd(caddr_t'(bus_wdata[CADDR_W:0])), .wdata_in(cw_q),
        .cdc_req(cdc_req), .cur_cmd(cur_cmd), .cdc_wdata(cdc_wdata),
        .cdc_done(cdc_done), .cdc_rdata(cdc_rdata),
        .rd_data(crd_q), .finished(acc_fin)
    );

    assign cdc_rd   = cur_cmd.rd;
    assign cdc_addr = cur_cmd.addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cw_q  <= '0;
            und_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (wr_en && word == REG_CWDATA) cw_q <= bus_wdata[SAMPLE_W-1:0];
            if (flush_play)                  und_q <= 1'b0;
            else if (play_take && play_empty) und_q <= 1'b1;
            if (flush_rec)                   ovr_q <= 1'b0;
            else if (rec_put && rec_full)    ovr_q <= 1'b1;
        end
    end

    always_comb begin
        stat_w.rec_ovr   = ovr_q;
        stat_w.play_und  = und_q;
        stat_w.codec_rdy = cdc_ready;
        stat_w.acc_done  = acc_fin;
        stat_w.rec_empty = rec_empty;
        stat_w.rec_full  = rec_full;
        stat_w.play_half = (play_cnt <= CW'(HALF));
        stat_w.play_full = play_full;
    end

    assign play_sample = play_empty ? '0 : play_head;
    assign play_irq    = stat_w.play_half;
    assign rec_irq     = (rec_cnt >= CW'(HALF));

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (word)
                REG_REC:    bus_rdata = rec_empty ? '0 : widen(rec_head);
                REG_STAT:   bus_rdata = {{(DATA_W-8){1'b0}}, stat_w};
                REG_CADDR:  bus_rdata = {{(DATA_W-CADDR_W-1){1'b0}}, cur_cmd};
                REG_CRDATA: bus_rdata = widen(crd_q);
                REG_CWDATA: bus_rdata = widen(cw_q);
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/audio_ctl_regs_chk.sv
module audio_ctl_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [4:0] bus_addr,
    input logic [1:0] bus_wbits,
    input logic       cdc_req,
    input logic       cdc_done,
    input logic       cdc_rd,
    input logic [6:0] cdc_addr,
    input logic [7:0] stat
);
    logic flush_wr, cmd_wr;
    assign flush_wr = bus_sel && bus_wr && bus_addr[4:2] == 3'd3;
    assign cmd_wr   = bus_sel && bus_wr && bus_addr[4:2] == 3'd4;

    // R5
    play_flush_chk: assert property (@(posedge clk) disable iff (rst)
        flush_wr && bus_wbits[0] |=> stat[1] && !stat[0] && !stat[6]);

    // R5
    rec_flush_chk: assert property (@(posedge clk) disable iff (rst)
        flush_wr && bus_wbits[1] |=> stat[3] && !stat[2] && !stat[7]);

    // R7
    launch_clr_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && !cdc_req |=> cdc_req && !stat[4]);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cdc_req && !cdc_done |=> cdc_req && $stable(cdc_addr) && $stable(cdc_rd));

    // R7
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        cdc_req && cdc_done |=> stat[4] && !cdc_req);

    // R9
    und_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stat[6] && !(flush_wr && bus_wbits[0]) |=> stat[6]);

    // R4
    rec_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !(stat[3] && stat[2]));
endmodule

bind audio_ctl_regs audio_ctl_regs_chk u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wbits(bus_wdata[1:0]),
    .cdc_req(cdc_req), .cdc_done(cdc_done), .cdc_rd(cdc_rd),
    .cdc_addr(cdc_addr), .stat(stat_w)
);

// File: tb/audio_ctl_regs_test.sv
module audio_ctl_regs_test;
    localparam int PERIOD = 10;

    logic        clk = 0, rst = 1;
    logic        bus_sel = 0, bus_wr = 0;
    logic [4:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        cdc_ready = 1, cdc_req, cdc_rd, cdc_done = 0;
    logic [6:0]  cdc_addr;
    logic [15:0] cdc_wdata, cdc_rdata = 0;
    logic        play_take = 0, rec_put = 0;
    logic [15:0] play_sample, rec_sample = 0;
    logic        play_irq, rec_irq;

    int checks = 0, errors = 0;
    bit finished = 0;

    audio_ctl_regs uut (.*);

    always #(PERIOD/2) clk = ~clk;

    // codec stub: answers after three cycles of request
    initial begin
        int waitc = 0;
        forever begin
            @(negedge clk);
            cdc_done = 0;
            if (cdc_req) begin
                waitc++;
                if (waitc == 3) begin
                    cdc_done  = 1;
                    cdc_rdata = 16'hC000 | {9'd0, cdc_addr};
                    waitc     = 0;
                end
            end else waitc = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic take_one();
        @(negedge clk); play_take = 1;
        @(negedge clk); play_take = 0;
    endtask

    task automatic put_one(input logic [15:0] s);
        @(negedge clk); rec_put = 1; rec_sample = s;
        @(negedge clk); rec_put = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(5'h08, d);
        chk("R4 reset status", d, 32'h0000_002A);
        chk("R10 reset play_irq", {31'd0, play_irq}, 1);
        chk("R10 reset rec_irq", {31'd0, rec_irq}, 0);
        chk("R11 reset play_sample", {16'd0, play_sample}, 0);
    endtask

    task automatic t_play();
        logic [31:0] d;
        for (int i = 0; i < 33; i++) bus_write(5'h00, 32'hABCD_0000 | (32'h100 + i));
        bus_read(5'h08, d);
        chk("R2 play full after 33 pushes", d & 32'h3, 32'h1);
        chk("R10 play_irq low when full", {31'd0, play_irq}, 0);
        for (int i = 0; i < 32; i++) begin
            chk("R2 play order", {16'd0, play_sample}, 32'h100 + i);
            chk("R10 play_irq level", {31'd0, play_irq}, (32 - i <= 16) ? 1 : 0);
            take_one();
        end
        chk("R11 play_sample zero when empty", {16'd0, play_sample}, 0);
        bus_read(5'h08, d);
        chk("R9 no underrun yet", (d >> 6) & 1, 0);
        take_one();
        bus_read(5'h08, d);
        chk("R9 underrun set", (d >> 6) & 1, 1);
    endtask

    task automatic t_rec();
        logic [31:0] d;
        for (int i = 0; i < 33; i++) put_one(16'h200 + 16'(i));
        bus_read(5'h08, d);
        chk("R9 overrun set", (d >> 7) & 1, 1);
        chk("R4 record full, not empty", d & 32'hC, 32'h4);
        for (int i = 0; i < 32; i++) begin
            chk("R10 rec_irq level", {31'd0, rec_irq}, (32 - i >= 16) ? 1 : 0);
            bus_read(5'h04, d);
            chk("R3 record order", d, 32'h200 + i);
        end
        bus_read(5'h04, d);
        chk("R11 empty pop returns zero", d, 0);
        bus_read(5'h08, d);
        chk("R11 record still empty", d & 32'hC, 32'h8);
        chk("R9 flags persist", d & 32'hC0, 32'hC0);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        bus_write(5'h00, 32'h1111);
        bus_write(5'h00, 32'h2222);
        put_one(16'h3333);
        put_one(16'h4444);
        bus_write(5'h0C, 32'h1);
        bus_read(5'h08, d);
        chk("R5 play-only flush", d & 32'hCF, 32'h82);
        bus_write(5'h0C, 32'h3);
        bus_read(5'h08, d);
        chk("R5 both flushed", d & 32'hCF, 32'h0A);
        chk("R5 play_sample zero", {16'd0, play_sample}, 0);
        bus_read(5'h0C, d);
        chk("R5 flush reg reads zero", d, 0);
        bus_read(5'h1C, d);
        chk("R1 unused offset reads zero", d, 0);
    endtask

    task automatic wait_fin();
        logic [31:0] d;
        for (int k = 0; k < 20; k++) begin
            bus_read(5'h08, d);
            if (d[4]) break;
        end
        chk("R7 finished bit sets", (d >> 4) & 1, 1);
    endtask

    task automatic t_codec();
        logic [31:0] d;
        bus_write(5'h18, 32'hFFFF_1234);
        bus_read(5'h18, d);
        chk("R1 write-data readback", d, 32'h1234);
        bus_write(5'h10, 32'h0A);
        chk("R6 req raised", {31'd0, cdc_req}, 1);
        chk("R6 write fields", {8'd0, cdc_rd, cdc_addr, cdc_wdata}, {8'd0, 1'b0, 7'h0A, 16'h1234});
        wait_fin();
        bus_read(5'h14, d);
        chk("R7 write leaves read data", d, 0);
        bus_write(5'h10, 32'h9C);
        bus_read(5'h08, d);
        chk("R7 launch clears finished", (d >> 4) & 1, 0);
        chk("R7 read direction", {24'd0, cdc_rd, cdc_addr}, {24'd0, 1'b1, 7'h1C});
        wait_fin();
        bus_read(5'h14, d);
        chk("R7 read data captured", d, 32'hC01C);
        bus_read(5'h10, d);
        chk("R1 command readback", d, 32'h9C);
        bus_write(5'h10, 32'h05);
        bus_write(5'h10, 32'hA2);
        chk("R8 busy launch ignored", {24'd0, cdc_rd, cdc_addr}, {24'd0, 1'b0, 7'h05});
        wait_fin();
        bus_read(5'h14, d);
        chk("R8 read data unchanged", d, 32'hC01C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_play();
        t_rec();
        t_flush();
        t_codec();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule